// File: doc/BRIEF.md
# Page Write-Wear Tracking Controller

This block sits at the front of a memory controller whose physical address space is split between a DRAM region and a phase-change (PRAM) region. Every request is steered to one of the two device ports by comparing its address with a fixed partition boundary. Writes that land in the PRAM region also advance a per-page write counter. The purpose is to let the operating system spread wear evenly over the endurance-limited pages.

The counters live in a backing map held in a reserved part of PRAM. A small fully associative cache with least-recently-used replacement sits in front of the map and is consulted only on PRAM writes. A miss stalls the request path while any dirty victim is written back and the needed entry is fetched. The fetched entry is then incremented on installation.

When a page's count lands on a nonzero multiple of the swap threshold, a swap interrupt carrying the page number is queued. When the count reaches the endurance limit, a terminal bad-page interrupt is queued instead and the count stops. Interrupts leave through a small queue with a valid/ready handshake. A flush input writes every modified cache entry back to the map so that the map can be copied elsewhere.

Top module: `wear_track_ctrl`

## Requirements
- R1: An accepted request (req_valid and req_ready both high) appears in the same cycle on exactly one device port, with the same address and write flag: the PRAM port when req_addr >= PRAM_BASE, the DRAM port otherwise.
- R2: Reads to either region and writes to the DRAM region cause no map access, raise no interrupt and leave every page count unchanged.
- R3: Each accepted PRAM write to page p = req_addr >> PAGE_BITS raises that page's count by one until the count reaches END_NW. In a map word, bits [CW-1:0] hold the count and the bits above hold the count modulo SWAP_NT, where CW = $clog2(END_NW+1).
- R4: A PRAM write whose new count is a nonzero multiple of SWAP_NT, and is below END_NW, queues one interrupt with irq_bad=0 and irq_page=p.
- R5: A PRAM write whose new count equals END_NW queues one interrupt with irq_bad=1 and irq_page=p, and no swap interrupt, even when END_NW is a multiple of SWAP_NT.
- R6: Once a page has reached END_NW, further writes to it queue no interrupt and leave its count unchanged.
- R7: A PRAM write that misses the cache issues exactly one map read of page p. It holds req_ready low until the entry returns, then installs the returned count plus one and applies R4 to R6 in that cycle.
- R8: On a miss with no free entry, the least recently written entry is the victim. If that victim was modified, it is written to the map on map_wr_valid in the cycle just before the map read.
- R9: Interrupts leave in the order they were raised. irq_valid stays high with a stable irq_bad/irq_page until irq_ready is seen. req_ready is low while the queue is full.
- R10: A flush request held in the idle state raises flush_busy and writes every modified entry back once, keeping req_ready low throughout. A second flush with no writes in between issues no map write.
- R11: After reset, req_ready is high, irq_valid, flush_busy, map_rd_valid and map_wr_valid are low, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Physical byte address |
| dram_valid | output | 1 | Request routed to DRAM |
| dram_write | output | 1 | Write flag to DRAM |
| dram_addr | output | ADDR_W | Address to DRAM |
| pram_valid | output | 1 | Request routed to PRAM |
| pram_write | output | 1 | Write flag to PRAM |
| pram_addr | output | ADDR_W | Address to PRAM |
| map_rd_valid | output | 1 | One-cycle read of a map word |
| map_wr_valid | output | 1 | One-cycle write of a map word |
| map_addr | output | ADDR_W-PAGE_BITS | Page number addressed in the map |
| map_wdata | output | RW+CW | Map word written {residue, count} |
| map_rvalid | input | 1 | Read data returned (one pulse per read) |
| map_rdata | input | RW+CW | Returned map word {residue, count} |
| flush | input | 1 | Request a write-back of all modified entries |
| flush_busy | output | 1 | Write-back walk in progress |
| irq_valid | output | 1 | Interrupt at queue head |
| irq_ready | input | 1 | Consumer takes the head interrupt |
| irq_bad | output | 1 | 1 = endurance limit, 0 = swap threshold |
| irq_page | output | ADDR_W-PAGE_BITS | Page number of the interrupt |

## Verification
The bench builds the block with a 16-bit address, 64-byte pages, PRAM from 0x8000, four cache entries, a swap threshold of 3, an endurance limit of 24 and an eight-deep interrupt queue. With a limit of 24, a page reaches the terminal interrupt after about two dozen writes, and that limit is also a multiple of the threshold, so the bad-page-instead-of-swap rule is exercised directly. Four entries against up to two dozen active pages force frequent eviction and write-back. A queue of eight fills exactly at the terminal interrupt of one page, which exposes the back-pressure stall. The map model answers reads after three cycles.

// File: rtl/wt_pkg.sv
package wt_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_WB    = 3'd1,
        ST_FETCH = 3'd2,
        ST_WAIT  = 3'd3,
        ST_FLUSH = 3'd4
    } wt_state_e;

endpackage

// File: rtl/wt_route.sv
module wt_route #(
    parameter int unsigned       ADDR_W    = 40,
    parameter logic [ADDR_W-1:0] PRAM_BASE = '0
) (
    input  logic              req_valid,
    input  logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              is_pram,
    output logic              dram_valid,
    output logic              dram_write,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              pram_valid,
    output logic              pram_write,
    output logic [ADDR_W-1:0] pram_addr
);

    logic take;

    always_comb begin
        is_pram    = (req_addr >= PRAM_BASE);
        take       = req_valid && req_ready;
        dram_valid = take && !is_pram;
        pram_valid = take && is_pram;
        dram_write = req_write;
        pram_write = req_write;
        dram_addr  = req_addr;
        pram_addr  = req_addr;
    end

endmodule

// File: rtl/wt_lru.sv
module wt_lru #(
    parameter int unsigned ENTRIES = 32,
    localparam int unsigned IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] oldest
);

    typedef struct packed {
        logic [ENTRIES-1:0][IW-1:0] age;
    } lru_t;

    lru_t r_d, r_q;
    logic [ENTRIES-1:0] old_vec;

    always_comb begin
        r_d = r_q;
        if (touch) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (r_q.age[j] < r_q.age[touch_idx]) begin
                    r_d.age[j] = r_q.age[j] + IW'(1);
                end
            end
            r_d.age[touch_idx] = '0;
        end
    end

    always_comb begin
        oldest  = '0;
        old_vec = '0;
        for (int j = 0; j < ENTRIES; j++) begin
            if (r_q.age[j] == IW'(ENTRIES - 1)) begin
                oldest     = IW'(j);
                old_vec[j] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < ENTRIES; j++) begin
                r_q.age[j] <= IW'(j);
            end
        end else begin
            r_q <= r_d;
        end
    end

    // R8: ages stay a permutation, so exactly one entry is the oldest
    a_r8_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(old_vec) == 1);

endmodule

// File: rtl/wt_irq_fifo.sv
module wt_irq_fifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 8,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNW  = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic         valid,
    output logic [W-1:0] head
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CNW-1:0]          cnt;
    } fifo_t;

    fifo_t r_d, r_q;
    logic  do_pop;

    always_comb begin
        full   = (r_q.cnt == CNW'(DEPTH));
        valid  = (r_q.cnt != '0);
        head   = r_q.mem[r_q.rp];
        do_pop = pop && valid;
        r_d    = r_q;
        if (push) begin
            r_d.mem[r_q.wp] = push_data;
            r_d.wp = (r_q.wp == PW'(DEPTH - 1)) ? '0 : r_q.wp + PW'(1);
        end
        if (do_pop) begin
            r_d.rp = (r_q.rp == PW'(DEPTH - 1)) ? '0 : r_q.rp + PW'(1);
        end
        r_d.cnt = r_q.cnt + CNW'(push) - CNW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R9: the request path never pushes into a full queue
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R9: an unacknowledged head stays put
    a_r9_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !pop) |=> (valid && $stable(head)));

endmodule

// File: rtl/wear_track_ctrl.sv
module wear_track_ctrl
    import wt_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 40,
    parameter int unsigned       PAGE_BITS = 12,
    parameter logic [ADDR_W-1:0] PRAM_BASE = ADDR_W'(64'h10_0000_0000),
    parameter int unsigned       ENTRIES   = 32,
    parameter int unsigned       SWAP_NT   = 1000,
    parameter int unsigned       END_NW    = 1000000000,
    parameter int unsigned       IRQ_DEPTH = 4,
    localparam int unsigned PN_W = ADDR_W - PAGE_BITS,
    localparam int unsigned CW   = $clog2(END_NW + 1),
    localparam int unsigned RW   = (SWAP_NT > 1) ? $clog2(SWAP_NT) : 1,
    localparam int unsigned MW   = RW + CW,
    localparam int unsigned IW   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              dram_valid,
    output logic              dram_write,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              pram_valid,
    output logic              pram_write,
    output logic [ADDR_W-1:0] pram_addr,
    output logic              map_rd_valid,
    output logic              map_wr_valid,
    output logic [PN_W-1:0]   map_addr,
    output logic [MW-1:0]     map_wdata,
    input  logic              map_rvalid,
    input  logic [MW-1:0]     map_rdata,
    input  logic              flush,
    output logic              flush_busy,
    output logic              irq_valid,
    input  logic              irq_ready,
    output logic              irq_bad,
    output logic [PN_W-1:0]   irq_page
);

    typedef struct packed {
        logic            vld;
        logic            dirty;
        logic [PN_W-1:0] tag;
        logic [RW-1:0]   res;
        logic [CW-1:0]   cnt;
    } ent_t;

    typedef struct packed {
        wt_state_e             st;
        logic [IW-1:0]         idx;
        logic [PN_W-1:0]       pg;
        ent_t [ENTRIES-1:0]    ent;
    } ctl_t;

    ctl_t r_d, r_q;

    // Advance one entry by a single write, saturating at the endurance limit
    function automatic ent_t bump(input ent_t e);
        ent_t o;
        o = e;
        if (e.cnt != CW'(END_NW)) begin
            o.cnt   = e.cnt + CW'(1);
            o.res   = (e.res == RW'(SWAP_NT - 1)) ? '0 : e.res + RW'(1);
            o.dirty = 1'b1;
        end
        return o;
    endfunction

    logic              is_pram;
    logic              accept;
    logic [PN_W-1:0]   req_pg;
    logic              hit;
    logic [IW-1:0]     hit_idx;
    logic              has_free;
    logic [IW-1:0]     free_idx;
    logic [IW-1:0]     lru_old;
    logic              fifo_full;
    logic              push;
    logic [PN_W:0]     push_data;
    logic [PN_W:0]     head;
    logic              do_bump;
    logic [IW-1:0]     b_idx;
    ent_t              b_in;
    ent_t              b_out;
    logic              b_sat;
    logic              b_bad;
    logic              b_swap;

    wt_route #(
        .ADDR_W    (ADDR_W),
        .PRAM_BASE (PRAM_BASE)
    ) u_route (
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .is_pram    (is_pram),
        .dram_valid (dram_valid),
        .dram_write (dram_write),
        .dram_addr  (dram_addr),
        .pram_valid (pram_valid),
        .pram_write (pram_write),
        .pram_addr  (pram_addr)
    );

    wt_lru #(
        .ENTRIES (ENTRIES)
    ) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (do_bump),
        .touch_idx (b_idx),
        .oldest    (lru_old)
    );

    wt_irq_fifo #(
        .DEPTH (IRQ_DEPTH),
        .W     (PN_W + 1)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (irq_ready),
        .full      (fifo_full),
        .valid     (irq_valid),
        .head      (head)
    );

    assign irq_bad    = head[PN_W];
    assign irq_page   = head[PN_W-1:0];
    assign flush_busy = (r_q.st == ST_FLUSH);
    assign req_ready  = (r_q.st == ST_RUN) && !fifo_full && !flush;
    assign accept     = req_valid && req_ready;
    assign req_pg     = req_addr[ADDR_W-1:PAGE_BITS];

    // Tag match and free-slot search
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        has_free = 1'b0;
        free_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (r_q.ent[i].vld && (r_q.ent[i].tag == req_pg)) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!r_q.ent[i].vld) begin
                has_free = 1'b1;
                free_idx = IW'(i);
            end
        end
    end

    // Next-state computation
    always_comb begin
        r_d          = r_q;
        map_rd_valid = 1'b0;
        map_wr_valid = 1'b0;
        map_addr     = '0;
        map_wdata    = '0;
        do_bump      = 1'b0;
        b_idx        = '0;
        b_in         = '0;

        unique case (r_q.st)
            ST_RUN: begin
                if (flush) begin
                    r_d.st  = ST_FLUSH;
                    r_d.idx = '0;
                end else if (accept && is_pram && req_write) begin
                    if (hit) begin
                        do_bump = 1'b1;
                        b_idx   = hit_idx;
                        b_in    = r_q.ent[hit_idx];
                    end else begin
                        r_d.idx = has_free ? free_idx : lru_old;
                        r_d.pg  = req_pg;
                        if (!has_free && r_q.ent[lru_old].dirty) begin
                            r_d.st = ST_WB;
                        end else begin
                            r_d.st = ST_FETCH;
                        end
                    end
                end
            end
            ST_WB: begin
                map_wr_valid             = 1'b1;
                map_addr                 = r_q.ent[r_q.idx].tag;
                map_wdata                = {r_q.ent[r_q.idx].res, r_q.ent[r_q.idx].cnt};
                r_d.ent[r_q.idx].dirty   = 1'b0;
                r_d.st                   = ST_FETCH;
            end
            ST_FETCH: begin
                map_rd_valid = 1'b1;
                map_addr     = r_q.pg;
                r_d.st       = ST_WAIT;
            end
            ST_WAIT: begin
                if (map_rvalid) begin
                    do_bump   = 1'b1;
                    b_idx     = r_q.idx;
                    b_in.vld  = 1'b1;
                    b_in.tag  = r_q.pg;
                    b_in.res  = map_rdata[MW-1:CW];
                    b_in.cnt  = map_rdata[CW-1:0];
                    r_d.st    = ST_RUN;
                end
            end
            ST_FLUSH: begin
                if (r_q.ent[r_q.idx].vld && r_q.ent[r_q.idx].dirty) begin
                    map_wr_valid           = 1'b1;
                    map_addr               = r_q.ent[r_q.idx].tag;
                    map_wdata              = {r_q.ent[r_q.idx].res, r_q.ent[r_q.idx].cnt};
                    r_d.ent[r_q.idx].dirty = 1'b0;
                end
                if (r_q.idx == IW'(ENTRIES - 1)) begin
                    r_d.st = ST_RUN;
                end else begin
                    r_d.idx = r_q.idx + IW'(1);
                end
            end
            default: r_d.st = ST_RUN;
        endcase

        b_out  = bump(b_in);
        b_sat  = (b_in.cnt == CW'(END_NW));
        b_bad  = !b_sat && (b_out.cnt == CW'(END_NW));
        b_swap = !b_sat && !b_bad && (b_out.res == '0);
        if (do_bump) begin
            r_d.ent[b_idx] = b_out;
        end
        push      = do_bump && (b_bad || b_swap);
        push_data = {b_bad, b_out.tag};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R8: a victim write-back is followed at once by the fetch
    a_r8_wb_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (map_wr_valid && !flush_busy) |=> map_rd_valid);

    // R7: a miss issues a single one-cycle map read
    a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        map_rd_valid |=> !map_rd_valid);

    // R7: no request is accepted while a miss is outstanding
    a_r7_stall_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        map_rd_valid |-> !req_ready);

    // R10: the flush walk blocks requests
    a_r10_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |-> !req_ready);

    // R9: a full queue stalls the request path
    a_r9_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !req_ready);

endmodule

// File: tb/sim_wear_track_ctrl.sv
module sim_wear_track_ctrl;

    localparam int CLK_P   = 10;
    localparam int AW      = 16;
    localparam int PB      = 6;
    localparam int NT      = 3;
    localparam int NW      = 24;
    localparam int ENT     = 4;
    localparam int QD      = 8;
    localparam int MAP_LAT = 3;
    localparam int PNW     = AW - PB;
    localparam int CW      = $clog2(NW + 1);
    localparam int RW      = $clog2(NT);
    localparam int MW      = CW + RW;
    localparam logic [AW-1:0] BASE = 16'h8000;
    localparam int NPG     = 1 << PNW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_ready;
    logic dram_valid, dram_write, pram_valid, pram_write;
    logic [AW-1:0] dram_addr, pram_addr;
    logic map_rd_valid, map_wr_valid;
    logic [PNW-1:0] map_addr;
    logic [MW-1:0] map_wdata;
    logic map_rvalid;
    logic [MW-1:0] map_rdata;
    logic flush = 1'b0;
    logic flush_busy;
    logic irq_valid, irq_bad;
    logic irq_ready = 1'b0;
    logic [PNW-1:0] irq_page;

    always #(CLK_P / 2) clk = ~clk;

    wear_track_ctrl #(
        .ADDR_W (AW), .PAGE_BITS (PB), .PRAM_BASE (BASE), .ENTRIES (ENT),
        .SWAP_NT (NT), .END_NW (NW), .IRQ_DEPTH (QD)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write), .req_addr (req_addr),
        .dram_valid (dram_valid), .dram_write (dram_write), .dram_addr (dram_addr),
        .pram_valid (pram_valid), .pram_write (pram_write), .pram_addr (pram_addr),
        .map_rd_valid (map_rd_valid), .map_wr_valid (map_wr_valid), .map_addr (map_addr),
        .map_wdata (map_wdata), .map_rvalid (map_rvalid), .map_rdata (map_rdata),
        .flush (flush), .flush_busy (flush_busy),
        .irq_valid (irq_valid), .irq_ready (irq_ready), .irq_bad (irq_bad), .irq_page (irq_page)
    );

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    int n_rd = 0;
    int n_wr = 0;
    int last_wb = -1;
    bit hold_irq = 1'b0;
    int ref_cnt [0:NPG-1];
    logic [PNW:0] exp_q [0:4095];
    int exp_h = 0;
    int exp_t = 0;
    int chk_page = -1;
    int chk_pre = 0;

    // Backing map model with a fixed read latency
    logic [MW-1:0] mem [0:NPG-1];
    int rd_pend;
    logic [PNW-1:0] rd_addr;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPG; i++) mem[i] <= '0;
            rd_pend    <= 0;
            rd_addr    <= '0;
            map_rvalid <= 1'b0;
            map_rdata  <= '0;
        end else begin
            if (map_wr_valid) mem[map_addr] <= map_wdata;
            map_rvalid <= 1'b0;
            if (map_rd_valid) begin
                rd_pend <= MAP_LAT;
                rd_addr <= map_addr;
            end else if (rd_pend > 0) begin
                rd_pend <= rd_pend - 1;
                if (rd_pend == 1) begin
                    map_rvalid <= 1'b1;
                    map_rdata  <= mem[rd_addr];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic int exp_residue(input int c);
        return c % NT;
    endfunction

    // Monitor: interrupt handshakes and map traffic, sampled away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            irq_ready <= hold_irq ? 1'b0 : ($urandom % 4 != 0);
            #1;
            if (irq_valid && irq_ready) begin
                if (exp_h == exp_t) begin
                    chk(1'b0, "R6", "interrupt with none expected, page", int'(irq_page), -1);
                end else begin
                    chk({irq_bad, irq_page} == exp_q[exp_h], exp_q[exp_h][PNW] ? "R5" : "R4",
                        "interrupt {bad,page}", int'({irq_bad, irq_page}), int'(exp_q[exp_h]));
                    exp_h++;
                end
            end
            if (map_rd_valid) begin
                n_rd++;
                chk(int'(map_addr) == chk_page, "R7", "map read page", int'(map_addr), chk_page);
                chk(int'(mem[map_addr][CW-1:0]) == chk_pre, "R8", "map count before fetch",
                    int'(mem[map_addr][CW-1:0]), chk_pre);
            end
            if (map_wr_valid) begin
                n_wr++;
                last_wb = int'(map_addr);
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_req(input bit wr, input logic [AW-1:0] a);
        bit ep;
        int pg;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        ep = (a >= BASE);
        chk((pram_valid == ep) && (dram_valid == !ep) &&
            (ep ? (pram_addr == a && pram_write == wr) : (dram_addr == a && dram_write == wr)),
            "R1", "route {pram_valid,dram_valid}", int'({pram_valid, dram_valid}), int'({ep, !ep}));
        @(posedge clk);
        if (ep && wr) begin
            pg = int'(a >> PB);
            chk_page = pg;
            chk_pre  = ref_cnt[pg];
            if (ref_cnt[pg] < NW) begin
                ref_cnt[pg]++;
                if (ref_cnt[pg] == NW) begin
                    exp_q[exp_t % 4096] = {1'b1, PNW'(pg)};
                    exp_t++;
                end else if (ref_cnt[pg] % NT == 0) begin
                    exp_q[exp_t % 4096] = {1'b0, PNW'(pg)};
                    exp_t++;
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [AW-1:0] paddr(input int k);
        return BASE | AW'(k << PB) | AW'($urandom % 64);
    endfunction

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        while (!flush_busy) @(negedge clk);
        flush = 1'b0;
        while (flush_busy) @(negedge clk);
    endtask

    task automatic cmp_map(input string rq);
        int bad;
        int first;
        bad = 0;
        first = -1;
        for (int p = 0; p < NPG; p++) begin
            if (int'(mem[p][CW-1:0]) != ref_cnt[p] ||
                int'(mem[p][MW-1:CW]) != exp_residue(ref_cnt[p])) begin
                bad++;
                if (first < 0) first = p;
            end
        end
        chk(bad == 0, rq, "map words mismatching after flush", bad, 0);
        if (first >= 0) $display("  first mismatching page %0d: map=%0d model=%0d",
                                 first, int'(mem[first][CW-1:0]), ref_cnt[first]);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int wb0;
        void'($urandom(32'd20240607));
        for (int p = 0; p < NPG; p++) ref_cnt[p] = 0;
        settle(3);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R11: reset state
        chk(req_ready == 1'b1, "R11", "req_ready after reset", int'(req_ready), 1);
        chk(!irq_valid && !flush_busy, "R11", "irq_valid|flush_busy after reset",
            int'({irq_valid, flush_busy}), 0);
        chk(!map_rd_valid && !map_wr_valid, "R11", "map strobes after reset",
            int'({map_rd_valid, map_wr_valid}), 0);

        // R2: reads and DRAM writes touch no counter
        do_req(1'b0, paddr(0));
        do_req(1'b1, 16'h1234);
        do_req(1'b0, 16'h0040);
        settle(6);
        chk(n_rd == 0 && n_wr == 0, "R2", "map accesses after reads/DRAM write", n_rd + n_wr, 0);
        chk(!irq_valid, "R2", "irq_valid after reads/DRAM write", int'(irq_valid), 0);

        // R7/R8: fill four entries, refresh page 0, then evict page 1
        for (int k = 0; k < 4; k++) begin
            do_req(1'b1, paddr(k));
            settle(8);
        end
        chk(n_rd == 4, "R7", "map reads after four misses", n_rd, 4);
        chk(n_wr == 0, "R8", "write-backs while free entries remain", n_wr, 0);
        do_req(1'b1, paddr(0));
        settle(4);
        chk(n_rd == 4, "R7", "map reads after a hit", n_rd, 4);
        do_req(1'b1, paddr(4));
        settle(8);
        chk(n_wr == 1 && last_wb == int'(BASE >> PB) + 1, "R8", "victim page written back",
            last_wb, int'(BASE >> PB) + 1);
        chk(n_rd == 5, "R7", "map reads after eviction", n_rd, 5);

        // R9/R5: fill the queue with one page's interrupts, hold the consumer
        hold_irq = 1'b1;
        settle(2);
        for (int i = 0; i < NW; i++) begin
            do_req(1'b1, paddr(5));
            settle(1);
        end
        settle(8);
        #1;
        chk(req_ready == 1'b0, "R9", "req_ready with queue full", int'(req_ready), 0);
        chk(irq_valid == 1'b1, "R9", "irq_valid with queue full", int'(irq_valid), 1);
        chk(exp_t - exp_h == QD, "R9", "expected interrupts pending", exp_t - exp_h, QD);
        hold_irq = 1'b0;
        settle(2);
        // R6: more writes past the limit
        for (int i = 0; i < 4; i++) do_req(1'b1, paddr(5));
        settle(40);
        chk(exp_h == exp_t, "R4", "interrupts still undelivered", exp_t - exp_h, 0);
        chk(!irq_valid, "R6", "irq_valid after saturated writes", int'(irq_valid), 0);

        // R10/R3: flush and compare, then flush again with nothing modified
        do_flush();
        settle(2);
        cmp_map("R3");
        wb0 = n_wr;
        do_flush();
        settle(2);
        chk(n_wr == wb0, "R10", "write-backs on clean second flush", n_wr - wb0, 0);

        // Random mixed traffic with occasional flushes
        for (int n = 0; n < 2000; n++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 6) begin
                do_req(($urandom % 10) < 7, paddr(int'($urandom % 20)));
            end else begin
                do_req($urandom % 2 == 1, AW'($urandom % 32768));
            end
            if (n % 500 == 499) begin
                do_flush();
                settle(1);
                cmp_map("R10");
            end
        end
        settle(80);
        do_flush();
        settle(2);
        cmp_map("R3");
        chk(exp_h == exp_t, "R9", "interrupts undelivered at end", exp_t - exp_h, 0);
        chk(!irq_valid, "R6", "irq_valid at end", int'(irq_valid), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule